// File: doc/BRIEF.md
# Power-up flash register loader

This block fills the local configuration registers of a chip from values stored in user flash. Right out of reset, and again each time software pulses the start input, it asks the flash page controller for pages, one at a time, starting at a fixed first user page. It walks each delivered page as a string of packed records and turns every record into one write on the local register bus. Loading stops at the first record whose leading byte is not a known format code.

Each record begins with a format byte and a target address byte. A 16-bit record carries two value bytes. A 32-bit record carries four value bytes and then two filler bytes, so records stay aligned inside a page. Values are stored most significant byte first. A busy output stays high while a load is in progress. An error output reports a load that had to be cut short because it ran out of pages or met a record that does not fit in its page.

Top module: `flash_reg_loader`

## Requirements
- R1: Leaving reset, the block is already loading: `busy_o` is 1, `pg_req_o` is 1 and `pg_num_o` equals `FIRST_PAGE`.
- R2: A one-cycle `start_i` while idle starts a new load from `FIRST_PAGE` at offset 0 and clears `err_o` in the next cycle. A `start_i` while `busy_o` is 1 has no effect: the running load continues with the same page sequence and writes.
- R3: `busy_o` stays 1 from the start of a load through its last bus write and page request, and returns to 0 when loading ends. While `busy_o` is 0, neither `pg_req_o` nor `wr_o` is asserted.
- R4: `pg_req_o` is held until the cycle in which `pg_ack_i` is 1. In that cycle `pg_data_i` holds the page, with page byte k on bits 8k+7..8k. Byte 0 is the format byte of the page's first record.
- R5: A record is a format byte, then an address byte, then value bytes. Format 0x01 has 2 value bytes and occupies 4 bytes. Format 0x02 has 4 value bytes followed by 2 ignored filler bytes and occupies 8 bytes. Value bytes are assembled most significant first.
- R6: A format byte other than 0x01 or 0x02 ends loading without a write and leaves `err_o` at 0.
- R7: Each record produces `wr_o` for exactly one cycle, with `wr_addr_o` equal to the record address and `wr_data_o` equal to the value zero-extended to 32 bits. No further write or page request follows until `wr_ack_i` is 1 in a cycle after that pulse.
- R8: When the records consumed in a page reach its last byte, the block requests page number plus one and continues from offset 0 of that page.
- R9: If a page after `MAX_PAGE` would be needed, loading stops with `err_o` set to 1.
- R10: A format-0x02 record that would run past the end of its page is not written, and loading stops with `err_o` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Software request to run the loader again |
| pg_req_o | output | 1 | Page fetch request to the flash page controller |
| pg_num_o | output | PAGE_W | Page number being requested |
| pg_ack_i | input | 1 | Page delivered; pg_data_i valid |
| pg_data_i | input | PAGE_BYTES*8 | Page contents, byte k on bits 8k+7..8k |
| wr_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Target register address |
| wr_data_o | output | 32 | Write value, zero-extended |
| wr_ack_i | input | 1 | Register bus write accepted |
| busy_o | output | 1 | Loading in progress |
| err_o | output | 1 | Last load was cut short |

## Verification
A corrupted read offset or format decode shows on the very next write as a wrong address or a wrong value. It also shows as a write count that differs from the image, and these effects appear within one record. A bad page counter shows at the next page request as a wrong page number, or as a load that ends with the wrong error flag. A state machine stuck between records shows as `busy_o` never falling, or as a second write strobe before the acknowledge arrives. The directed images mix both record formats, fill pages completely, and place end markers and misfit records at page starts and at page ends, so that each of these faults changes the write log or the page request log.

// File: rtl/frl_pkg.sv
package frl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_PARSE = 3'd2,
        ST_WRITE = 3'd3,
        ST_WAIT  = 3'd4
    } ldr_st_e;

    localparam logic [7:0] FMT_W16 = 8'h01;
    localparam logic [7:0] FMT_W32 = 8'h02;

    localparam int REC16_BYTES = 4;
    localparam int REC32_BYTES = 8;
    localparam int REC_HDR_BYTES = 2;
    localparam int REC_PEEK_BYTES = 6;

endpackage

// File: rtl/frl_page_buf.sv
module frl_page_buf #(
    parameter int PAGE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [PAGE_BYTES*8-1:0] data_i,
    output logic [PAGE_BYTES*8-1:0] data_o
);

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= 8'h00;
            end else if (load_i) begin
                byte_q <= data_i[8*g +: 8];
            end
        end
        assign data_o[8*g +: 8] = byte_q;
    end

endmodule

// File: rtl/frl_rec_decode.sv
module frl_rec_decode
    import frl_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    localparam int IDX_W = $clog2(PAGE_BYTES),
    localparam int OFF_W = IDX_W + 1
) (
    input  logic [PAGE_BYTES*8-1:0] page_i,
    input  logic [OFF_W-1:0]        off_i,
    output logic                    is16_o,
    output logic                    is32_o,
    output logic                    fits_o,
    output logic [OFF_W-1:0]        len_o,
    output logic [7:0]              addr_o,
    output logic [31:0]             value_o
);

    logic [7:0] peek [REC_PEEK_BYTES];

    for (genvar k = 0; k < REC_PEEK_BYTES; k++) begin : g_peek
        logic [IDX_W-1:0] idx;
        assign idx     = off_i[IDX_W-1:0] + IDX_W'(k);
        assign peek[k] = page_i[{idx, 3'b000} +: 8];
    end

    logic [OFF_W:0] rec_end;

    always_comb begin
        is16_o  = (peek[0] == FMT_W16);
        is32_o  = (peek[0] == FMT_W32);
        len_o   = is32_o ? OFF_W'(REC32_BYTES) : OFF_W'(REC16_BYTES);
        rec_end = {1'b0, off_i} + {1'b0, len_o};
        fits_o  = (rec_end <= (OFF_W+1)'(PAGE_BYTES));
        addr_o  = peek[1];
        if (is32_o) begin
            value_o = {peek[2], peek[3], peek[4], peek[5]};
        end else begin
            value_o = {16'h0000, peek[2], peek[3]};
        end
    end

endmodule

// File: rtl/flash_reg_loader.sv
module flash_reg_loader
    import frl_pkg::*;
#(
    parameter int              PAGE_BYTES = 16,
    parameter int              PAGE_W     = 13,
    parameter logic [PAGE_W-1:0] FIRST_PAGE = 13'd4,
    parameter logic [PAGE_W-1:0] MAX_PAGE   = 13'd7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    output logic                    pg_req_o,
    output logic [PAGE_W-1:0]       pg_num_o,
    input  logic                    pg_ack_i,
    input  logic [PAGE_BYTES*8-1:0] pg_data_i,
    output logic                    wr_o,
    output logic [7:0]              wr_addr_o,
    output logic [31:0]             wr_data_o,
    input  logic                    wr_ack_i,
    output logic                    busy_o,
    output logic                    err_o
);

    localparam int OFF_W = $clog2(PAGE_BYTES) + 1;

    typedef struct packed {
        ldr_st_e          st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0] off;
        logic [7:0]       addr;
        logic [31:0]      data;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    logic [PAGE_BYTES*8-1:0] page_buf;
    logic                    buf_load;
    logic                    dec_is16, dec_is32, dec_fits;
    logic [OFF_W-1:0]        dec_len;
    logic [7:0]              dec_addr;
    logic [31:0]             dec_value;
    logic [OFF_W:0]          next_off;

    assign buf_load = (r_q.st == ST_REQ) && pg_ack_i;

    frl_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (buf_load),
        .data_i (pg_data_i),
        .data_o (page_buf)
    );

    frl_rec_decode #(.PAGE_BYTES(PAGE_BYTES)) u_dec (
        .page_i  (page_buf),
        .off_i   (r_q.off),
        .is16_o  (dec_is16),
        .is32_o  (dec_is32),
        .fits_o  (dec_fits),
        .len_o   (dec_len),
        .addr_o  (dec_addr),
        .value_o (dec_value)
    );

    assign next_off = {1'b0, r_q.off} + {1'b0, dec_len};

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_REQ;
                    r_d.page = FIRST_PAGE;
                    r_d.off  = '0;
                    r_d.err  = 1'b0;
                end
            end
            ST_REQ: begin
                if (pg_ack_i) begin
                    r_d.st  = ST_PARSE;
                    r_d.off = '0;
                end
            end
            ST_PARSE: begin
                if (dec_is16 || dec_is32) begin
                    if (dec_fits) begin
                        r_d.st   = ST_WRITE;
                        r_d.addr = dec_addr;
                        r_d.data = dec_value;
                    end else begin
                        r_d.st  = ST_IDLE;
                        r_d.err = 1'b1;
                    end
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_WRITE: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (wr_ack_i) begin
                    if (next_off >= (OFF_W+1)'(PAGE_BYTES)) begin
                        if (r_q.page == MAX_PAGE) begin
                            r_d.st  = ST_IDLE;
                            r_d.err = 1'b1;
                        end else begin
                            r_d.st   = ST_REQ;
                            r_d.page = r_q.page + 1'b1;
                            r_d.off  = '0;
                        end
                    end else begin
                        r_d.st  = ST_PARSE;
                        r_d.off = next_off[OFF_W-1:0];
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_REQ;
            r_q.page <= FIRST_PAGE;
            r_q.off  <= '0;
            r_q.addr <= '0;
            r_q.data <= '0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pg_req_o  = (r_q.st == ST_REQ);
    assign pg_num_o  = r_q.page;
    assign wr_o      = (r_q.st == ST_WRITE);
    assign wr_addr_o = r_q.addr;
    assign wr_data_o = r_q.data;
    assign busy_o    = (r_q.st != ST_IDLE);
    assign err_o     = r_q.err;

endmodule

// File: rtl/frl_checker.sv
module frl_checker #(
    parameter int                PAGE_W     = 13,
    parameter logic [PAGE_W-1:0] FIRST_PAGE = 13'd4,
    parameter logic [PAGE_W-1:0] MAX_PAGE   = 13'd7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pg_req_o,
    input logic [PAGE_W-1:0] pg_num_o,
    input logic              pg_ack_i,
    input logic              wr_o,
    input logic              wr_ack_i,
    input logic              busy_o,
    input logic              err_o
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_o) begin
            pend_q <= 1'b1;
        end else if (wr_ack_i) begin
            pend_q <= 1'b0;
        end
    end

    // R7
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);

    // R7
    wr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o || pg_req_o) |-> !pend_q);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_req_o && !pg_ack_i) |=> pg_req_o);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(pg_req_o || wr_o));

    // R9
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req_o |-> (pg_num_o >= FIRST_PAGE && pg_num_o <= MAX_PAGE));

    // R8
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pg_req_o) && $past(busy_o)) |-> (pg_num_o == PAGE_W'($past(pg_num_o) + 1'b1)));

    // R10
    err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $fell(busy_o));

endmodule

bind flash_reg_loader frl_checker #(
    .PAGE_W     (PAGE_W),
    .FIRST_PAGE (FIRST_PAGE),
    .MAX_PAGE   (MAX_PAGE)
) u_frl_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_req_o (pg_req_o),
    .pg_num_o (pg_num_o),
    .pg_ack_i (pg_ack_i),
    .wr_o     (wr_o),
    .wr_ack_i (wr_ack_i),
    .busy_o   (busy_o),
    .err_o    (err_o)
);

// File: tb/tb_flash_reg_loader.sv
module tb_flash_reg_loader;

    localparam int PB = 16;
    localparam int PW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          pg_req_o;
    logic [PW-1:0] pg_num_o;
    logic          pg_ack_i = 1'b0;
    logic [PB*8-1:0] pg_data_i = '0;
    logic          wr_o;
    logic [7:0]    wr_addr_o;
    logic [31:0]   wr_data_o;
    logic          wr_ack_i = 1'b0;
    logic          busy_o;
    logic          err_o;

    always #4 clk = ~clk;

    flash_reg_loader #(
        .PAGE_BYTES (PB),
        .PAGE_W     (PW),
        .FIRST_PAGE (13'd4),
        .MAX_PAGE   (13'd7)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pg_req_o(pg_req_o), .pg_num_o(pg_num_o), .pg_ack_i(pg_ack_i), .pg_data_i(pg_data_i),
        .wr_o(wr_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .busy_o(busy_o), .err_o(err_o)
    );

    int checks = 0;
    int fails = 0;

    logic [7:0]  img [8][PB];
    logic [7:0]  log_a [64];
    logic [31:0] log_d [64];
    logic [7:0]  exp_a [64];
    logic [31:0] exp_d [64];
    int          wr_cnt = 0;
    int          exp_n = 0;
    int          req_log [16];
    int          req_cnt = 0;
    int          overlap = 0;
    int          wide = 0;
    int          idle_act = 0;
    int          ack_dly = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PB*8-1:0] build(input int p);
        logic [PB*8-1:0] v;
        for (int k = 0; k < PB; k++) v[8*k +: 8] = img[p][k];
        return v;
    endfunction

    // page controller model
    int pg_wait = 0;
    int cur_pg = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pg_ack_i = 1'b0;
                pg_wait = 0;
            end else if (pg_ack_i) begin
                pg_ack_i = 1'b0;
            end else if (pg_wait > 0) begin
                pg_wait--;
                if (pg_wait == 0) begin
                    pg_data_i = build(cur_pg);
                    pg_ack_i = 1'b1;
                end
            end else if (pg_req_o) begin
                if (!busy_o) idle_act++;
                if (req_cnt < 16) req_log[req_cnt] = int'(pg_num_o);
                req_cnt++;
                cur_pg = int'(pg_num_o[2:0]);
                pg_wait = 3;
            end
        end
    end

    // register bus model
    bit pend = 1'b0;
    bit prev_wr = 1'b0;
    int wcnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (wr_ack_i) wr_ack_i = 1'b0;
            if (!rst_n) begin
                pend = 1'b0;
            end else if (wr_o) begin
                if (pend) overlap++;
                if (prev_wr) wide++;
                if (!busy_o) idle_act++;
                if (wr_cnt < 64) begin
                    log_a[wr_cnt] = wr_addr_o;
                    log_d[wr_cnt] = wr_data_o;
                end
                wr_cnt++;
                pend = 1'b1;
                wcnt = ack_dly;
            end else if (pend) begin
                if (wcnt > 1) wcnt--;
                else begin
                    wr_ack_i = 1'b1;
                    pend = 1'b0;
                end
            end
            prev_wr = wr_o;
        end
    end

    task automatic clear_img();
        for (int p = 0; p < 8; p++)
            for (int k = 0; k < PB; k++) img[p][k] = 8'hAA;
    endtask

    task automatic put16(input int p, input int o, input logic [7:0] a, input logic [15:0] d);
        img[p][o] = 8'h01; img[p][o+1] = a;
        img[p][o+2] = d[15:8]; img[p][o+3] = d[7:0];
        exp_a[exp_n] = a; exp_d[exp_n] = {16'h0, d}; exp_n++;
    endtask

    task automatic put32(input int p, input int o, input logic [7:0] a, input logic [31:0] d);
        img[p][o] = 8'h02; img[p][o+1] = a;
        img[p][o+2] = d[31:24]; img[p][o+3] = d[23:16];
        img[p][o+4] = d[15:8];  img[p][o+5] = d[7:0];
        img[p][o+6] = 8'h55;    img[p][o+7] = 8'h66;
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
    endtask

    task automatic clear_logs();
        wr_cnt = 0; req_cnt = 0; overlap = 0; wide = 0; exp_n = 0; idle_act = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_run(input string req, input bit exp_err, input int first_pg, input int n_pg);
        chk(wr_cnt == exp_n, req, "write count", 64'(wr_cnt), 64'(exp_n));
        for (int i = 0; i < exp_n && i < wr_cnt; i++) begin
            chk(log_a[i] == exp_a[i], req, "write address", 64'(log_a[i]), 64'(exp_a[i]));
            chk(log_d[i] == exp_d[i], req, "write value", 64'(log_d[i]), 64'(exp_d[i]));
        end
        chk(req_cnt == n_pg, req, "page requests", 64'(req_cnt), 64'(n_pg));
        for (int i = 0; i < n_pg && i < req_cnt; i++)
            chk(req_log[i] == first_pg + i, "R8", "page number", 64'(req_log[i]), 64'(first_pg + i));
        chk(err_o == exp_err, req, "error flag", 64'(err_o), 64'(exp_err));
        chk(!busy_o, "R3", "busy after end", 64'(busy_o), 64'd0);
        chk(overlap == 0, "R7", "write before ack", 64'(overlap), 64'd0);
        chk(wide == 0, "R7", "wide write strobe", 64'(wide), 64'd0);
        chk(idle_act == 0, "R3", "activity while idle", 64'(idle_act), 64'd0);
    endtask

    // R1 R5 R6 R8: power-up load, mixed formats, end marker on second page
    task automatic test_powerup();
        clear_img(); clear_logs();
        put16(4, 0, 8'h10, 16'hBEEF);
        put32(4, 4, 8'h22, 32'h1234_5678);
        put16(4, 12, 8'h11, 16'h0102);
        img[5][0] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b1, "R1", "busy out of reset", 64'(busy_o), 64'd1);
        chk(pg_req_o == 1'b1, "R1", "request out of reset", 64'(pg_req_o), 64'd1);
        chk(pg_num_o == 13'd4, "R1", "first page", 64'(pg_num_o), 64'd4);
        chk(err_o == 1'b0, "R1", "error out of reset", 64'(err_o), 64'd0);
        wait_idle();
        check_run("R5", 1'b0, 4, 2);
    endtask

    // R9 R8 R7: every page full, slow acknowledge, runs past the last page
    task automatic test_max_page();
        clear_img(); clear_logs();
        ack_dly = 5;
        for (int p = 4; p < 8; p++)
            for (int k = 0; k < 4; k++)
                put16(p, 4*k, 8'(16*p + k), 16'((p << 8) | k));
        pulse_start();
        wait_idle();
        check_run("R9", 1'b1, 4, 4);
        ack_dly = 1;
    endtask

    // R2 R5: restart clears the error, 32-bit page then 16-bit page
    task automatic test_restart();
        clear_img(); clear_logs();
        put32(4, 0, 8'h30, 32'hDEAD_BEEF);
        put32(4, 8, 8'h31, 32'h0000_00FF);
        put16(5, 0, 8'h40, 16'h8001);
        put16(5, 4, 8'h41, 16'h0000);
        put16(5, 8, 8'h42, 16'hFFFF);
        put16(5, 12, 8'h43, 16'h7F80);
        img[6][0] = 8'hFF;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(err_o == 1'b0, "R2", "error cleared by start", 64'(err_o), 64'd0);
        chk(busy_o == 1'b1, "R2", "busy after start", 64'(busy_o), 64'd1);
        wait_idle();
        check_run("R2", 1'b0, 4, 3);
    endtask

    // R10: 32-bit record at the last 4 bytes of a page
    task automatic test_misfit();
        clear_img(); clear_logs();
        put16(4, 0, 8'h01, 16'h1111);
        put16(4, 4, 8'h02, 16'h2222);
        put16(4, 8, 8'h03, 16'h3333);
        img[4][12] = 8'h02; img[4][13] = 8'h04;
        pulse_start();
        wait_idle();
        check_run("R10", 1'b1, 4, 1);
    endtask

    // R2: start pulses during a running load are ignored
    task automatic test_start_busy();
        clear_img(); clear_logs();
        put16(4, 0, 8'h50, 16'hA5A5);
        put32(4, 4, 8'h51, 32'hCAFE_0001);
        put16(4, 12, 8'h52, 16'h5A5A);
        img[5][0] = 8'h07;
        pulse_start();
        repeat (8) @(negedge clk);
        chk(busy_o == 1'b1, "R2", "busy before extra start", 64'(busy_o), 64'd1);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (6) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_idle();
        check_run("R2", 1'b0, 4, 2);
    endtask

    // R6: unknown format at the very first byte ends with no write
    task automatic test_empty();
        clear_img(); clear_logs();
        img[4][0] = 8'h03;
        pulse_start();
        wait_idle();
        check_run("R6", 1'b0, 4, 1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        test_powerup();
        test_max_page();
        test_restart();
        test_misfit();
        test_start_busy();
        test_empty();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

endmodule